// File: doc/BRIEF.md
# Per-Output Clock Gating Control

This block decides, for each of four clock outputs, what the output pad sees. Each channel picks one of three clock sources: the shared crystal clock, the shared external input clock, or a divider output belonging to that channel. The chosen clock can be inverted. It then passes an enable gate and a power-down switch. The result is a data value and a tristate enable for each channel, which a pad cell consumes.

A channel is shut off by its own bit in a disable register. It can also be shut off by an external active-high disable pin, unless the channel masks that pin. A 2-bit code per channel sets what the output does while it is shut off: hold low, hold high, float, or ignore the shut-off request and keep running.

Configuration is held in eight byte-wide registers behind a simple write-enable/address/data port. Reads are combinational. Clock inputs are treated as data and pass through combinational logic to the outputs. The only state in the block is the configuration.

Top module: `clkgate_ctl`

## Requirements
- R1: After reset every configuration register reads 0x00. Every channel then has `clk_oe`=1 and `clk_val` equal to `xtal_clk`.
- R2: Register map (address, then byte):
  - 0: disable
  - 1: pin mask
  - 2: disable codes for channels 0/1
  - 3: disable codes for channels 2/3
  - 4..7: control byte for channels 0..3

  A write with `cfg_we`=1 stores the full byte at the clock edge. `cfg_rdata` returns the full byte at `cfg_addr` in the same cycle.
- R3: Control byte bits 3:2 select the source: 00 crystal, 01 external input, 11 the channel's own `div_clk` bit. Control bit 4 set inverts the selected clock.
- R4: Source code 10 drives a constant low while the channel runs, whether or not the invert bit is set.
- R5: The disable register uses bit 1 for channel 0, bit 2 for channel 1, bit 5 for channel 2 and bit 7 for channel 3. A 1 shuts that channel off. Other channels are unaffected.
- R6: `oe_pin_dis`=1 shuts off every channel whose mask bit is 0. The mask register uses the same bit positions as the disable register. A mask bit of 1 makes the channel ignore the pin.
- R7: Disable codes sit at bits 3:2 (channel 0) and 5:4 (channel 1) of address 2, and at bits 3:2 (channel 2) and 7:6 (channel 3) of address 3. A shut-off channel behaves as follows:
  - code 00: `clk_val`=0, `clk_oe`=1
  - code 01: `clk_val`=1, `clk_oe`=1
  - code 10: `clk_val`=0, `clk_oe`=0
- R8: Disable code 11 keeps the channel running regardless of its disable bit and the pin.
- R9: Control bit 7 set gives `clk_oe`=0 and `clk_val`=0, whatever the enable state or disable code.
- R10: The held-low and held-high levels of a shut-off channel are not affected by the invert bit.
- R11: Control bits 1:0 are stored and read back but do not change any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| xtal_clk | input | 1 | Crystal clock source |
| ext_clk | input | 1 | External input clock source |
| div_clk | input | 4 | Per-channel divider clocks |
| oe_pin_dis | input | 1 | External active-high disable pin |
| clk_val | output | 4 | Output data value per channel |
| clk_oe | output | 4 | Output tristate enable per channel |

## Verification
On every cycle, the assertions check the following:
- the power-down override;
- that code 11 keeps a channel enabled;
- the float and held-high levels of a shut-off channel;
- the reserved source staying low;
- that an unmasked, unset channel stays enabled;
- that writes land and that registers hold without a write.

The bench's scenarios alone show that the bit positions of the disable, mask and code fields map to the right channel, and that each source code routes the intended clock with the right polarity. They also show that inversion leaves the held levels untouched, and that the drive bits change nothing at the outputs.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    localparam int NCH    = 4;
    localparam int REG_W  = 8;
    localparam int NREG   = 8;
    localparam int ADDR_W = $clog2(NREG);

    localparam int A_DIS   = 0;
    localparam int A_MASK  = 1;
    localparam int A_DST01 = 2;
    localparam int A_DST23 = 3;
    localparam int A_CTRL0 = 4;

    localparam int B_PDN = 7;
    localparam int B_INV = 4;
    localparam int B_SRC = 2;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_RSVD = 2'b10,
        SRC_DIV  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        OFF_LOW  = 2'b00,
        OFF_HIGH = 2'b01,
        OFF_HIZ  = 2'b10,
        OFF_NONE = 2'b11
    } off_e;

    // bit position of a channel in the disable and mask registers
    function automatic int dis_pos(input int ch);
        case (ch)
            0:       return 1;
            1:       return 2;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

    // low bit of a channel's disable code within its byte
    function automatic int dst_pos(input int ch);
        case (ch)
            0:       return 2;
            1:       return 4;
            2:       return 2;
            default: return 6;
        endcase
    endfunction

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
    } cfg_t;
endpackage

// File: rtl/clkgate_cfg.sv
module clkgate_cfg
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [NCH-1:0]    ch_pdn,
    output logic [NCH-1:0]    ch_inv,
    output logic [NCH-1:0][1:0] ch_src,
    output logic [NCH-1:0][1:0] ch_off,
    output logic [NCH-1:0]    ch_dis,
    output logic [NCH-1:0]    ch_mask
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.regs[cfg_addr] = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_rdata = cfg_q.regs[cfg_addr];

    for (genvar g = 0; g < NCH; g++) begin : g_field
        localparam int DP = dis_pos(g);
        localparam int OP = dst_pos(g);
        localparam int OA = (g < 2) ? A_DST01 : A_DST23;
        assign ch_dis[g]  = cfg_q.regs[A_DIS][DP];
        assign ch_mask[g] = cfg_q.regs[A_MASK][DP];
        assign ch_off[g]  = cfg_q.regs[OA][OP+1:OP];
        assign ch_pdn[g]  = cfg_q.regs[A_CTRL0+g][B_PDN];
        assign ch_inv[g]  = cfg_q.regs[A_CTRL0+g][B_INV];
        assign ch_src[g]  = cfg_q.regs[A_CTRL0+g][B_SRC+1:B_SRC];
    end

    // R2: a write is visible on the read port one edge later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q.regs[$past(cfg_addr)] == $past(cfg_wdata)));

    // R2: nothing changes without a write
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/clkgate_chan.sv
module clkgate_chan
    import clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn,
    input  logic       inv,
    input  logic [1:0] src,
    input  logic [1:0] off,
    input  logic       dis_bit,
    input  logic       mask_bit,
    input  logic       pin_dis,
    input  logic       xtal_clk,
    input  logic       ext_clk,
    input  logic       div_clk,
    output logic       val,
    output logic       oe
);
    logic sel_clk;
    logic pol_clk;
    logic shut;

    always_comb begin
        case (src_e'(src))
            SRC_XTAL: sel_clk = xtal_clk;
            SRC_EXT:  sel_clk = ext_clk;
            SRC_DIV:  sel_clk = div_clk;
            default:  sel_clk = 1'b0;
        endcase
        pol_clk = (src_e'(src) == SRC_RSVD) ? 1'b0 : (sel_clk ^ inv);
        shut    = (dis_bit | (pin_dis & ~mask_bit)) & (off_e'(off) != OFF_NONE);

        val = pol_clk;
        oe  = 1'b1;
        if (pdn) begin
            val = 1'b0;
            oe  = 1'b0;
        end else if (shut) begin
            case (off_e'(off))
                OFF_LOW:  begin val = 1'b0; oe = 1'b1; end
                OFF_HIGH: begin val = 1'b1; oe = 1'b1; end
                default:  begin val = 1'b0; oe = 1'b0; end
            endcase
        end
    end

    a_r9_pdn_float: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |-> (!oe && !val));

    a_r8_never_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && off == 2'b11) |-> oe);

    a_r7_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && dis_bit && off == 2'b10) |-> !oe);

    a_r10_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && dis_bit && off == 2'b01) |-> (oe && val));

    a_r4_rsvd_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && src == 2'b10 && off == 2'b11) |-> !val);

    a_r6_pin_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && !dis_bit && (mask_bit || !pin_dis)) |-> oe);
endmodule

// File: rtl/clkgate_ctl.sv
module clkgate_ctl
    import clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              xtal_clk,
    input  logic              ext_clk,
    input  logic [NCH-1:0]    div_clk,
    input  logic              oe_pin_dis,
    output logic [NCH-1:0]    clk_val,
    output logic [NCH-1:0]    clk_oe
);
    logic [NCH-1:0]      ch_pdn, ch_inv, ch_dis, ch_mask;
    logic [NCH-1:0][1:0] ch_src, ch_off;

    clkgate_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ch_pdn    (ch_pdn),
        .ch_inv    (ch_inv),
        .ch_src    (ch_src),
        .ch_off    (ch_off),
        .ch_dis    (ch_dis),
        .ch_mask   (ch_mask)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        clkgate_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pdn      (ch_pdn[g]),
            .inv      (ch_inv[g]),
            .src      (ch_src[g]),
            .off      (ch_off[g]),
            .dis_bit  (ch_dis[g]),
            .mask_bit (ch_mask[g]),
            .pin_dis  (oe_pin_dis),
            .xtal_clk (xtal_clk),
            .ext_clk  (ext_clk),
            .div_clk  (div_clk[g]),
            .val      (clk_val[g]),
            .oe       (clk_oe[g])
        );
    end
endmodule

// File: tb/sim_clkgate_ctl.sv
module sim_clkgate_ctl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       xtal_clk = 1'b0, ext_clk = 1'b0, oe_pin_dis = 1'b0;
    logic [3:0] div_clk = '0;
    logic [3:0] clk_val, clk_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    clkgate_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xtal_clk(xtal_clk),
        .ext_clk(ext_clk), .div_clk(div_clk), .oe_pin_dis(oe_pin_dis),
        .clk_val(clk_val), .clk_oe(clk_oe)
    );

    // fields: req[41:38] ctrl0[37:30] dis[29:22] mask[21:14] dst01[13:6]
    //         pin[5] xtal[4] ext[3] div0[2] exp_val[1] exp_oe[0]
    localparam int NV = 18;
    localparam logic [41:0] VEC [NV] = '{
        {4'd3,  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 crystal high
        {4'd3,  8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 crystal low
        {4'd3,  8'h04, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 external
        {4'd3,  8'h0C, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 divider
        {4'd3,  8'h1C, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 divider inverted
        {4'd4,  8'h08, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 reserved
        {4'd4,  8'h18, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 reserved inverted
        {4'd5,  8'h00, 8'h02, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 disabled, code 00
        {4'd5,  8'h00, 8'hFD, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 other bits only
        {4'd7,  8'h00, 8'h02, 8'h00, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 code 01
        {4'd7,  8'h00, 8'h02, 8'h00, 8'h08, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 code 10
        {4'd8,  8'h00, 8'h02, 8'h00, 8'h0C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 code 11
        {4'd6,  8'h00, 8'h00, 8'h00, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 pin unmasked
        {4'd6,  8'h00, 8'h00, 8'h02, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 pin masked
        {4'd9,  8'h80, 8'h00, 8'h00, 8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 power-down
        {4'd10, 8'h10, 8'h02, 8'h00, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R10 held high, inverted
        {4'd11, 8'h03, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R11 drive bits
        {4'd11, 8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R11 drive bits, divider
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), 8'h00);
        xtal_clk = 1'b1; #1;
        chk("R1 oe after reset", {4'h0, clk_oe}, 8'h0F);
        chk("R1 val follows crystal", {4'h0, clk_val}, 8'h0F);
        xtal_clk = 1'b0; #1;
        chk("R1 val follows crystal low", {4'h0, clk_val}, 8'h00);

        // R2: readback of each address
        for (int a = 0; a < 8; a++) begin
            wr(3'(a), 8'(8'h5A ^ (a * 8'h11)));
        end
        for (int a = 0; a < 8; a++) rd_chk("R2 readback", 3'(a), 8'(8'h5A ^ (a * 8'h11)));
        for (int a = 0; a < 8; a++) wr(3'(a), 8'h00);

        // table walk on channel 0
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, VEC[i][37:30]);
            wr(3'd0, VEC[i][29:22]);
            wr(3'd1, VEC[i][21:14]);
            wr(3'd2, VEC[i][13:6]);
            oe_pin_dis = VEC[i][5]; xtal_clk = VEC[i][4];
            ext_clk = VEC[i][3]; div_clk = {3'b000, VEC[i][2]};
            #1;
            n_chk++;
            if ({clk_val[0], clk_oe[0]} !== VEC[i][1:0]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual val/oe %b%b expected %b", VEC[i][41:38], i,
                         clk_val[0], clk_oe[0], VEC[i][1:0]);
            end
        end
        // R11: drive bits read back
        rd_chk("R11 ctrl0 readback", 3'd4, 8'h0F);
        for (int a = 0; a < 8; a++) wr(3'(a), 8'h00);
        oe_pin_dis = 1'b0; div_clk = '0;

        // R5 R7: channel 1 disable bit 2, code bits 5:4 = 01
        xtal_clk = 1'b0;
        wr(3'd2, 8'h10);
        wr(3'd0, 8'h04);
        chk("R5 R7 ch1 held high", {6'h0, clk_val[1], clk_oe[1]}, 8'h03);
        chk("R5 ch0 unaffected", {6'h0, clk_val[0], clk_oe[0]}, 8'h01);
        // R5 R7: channel 2 bit 5, code at bits 3:2 of addr 3 = 10
        wr(3'd3, 8'h08);
        wr(3'd0, 8'h20);
        chk("R7 ch2 float", {6'h0, clk_val[2], clk_oe[2]}, 8'h00);
        // channel 3 bit 7, code at bits 7:6 = 01
        wr(3'd3, 8'h40);
        wr(3'd0, 8'h80);
        chk("R7 ch3 held high", {6'h0, clk_val[3], clk_oe[3]}, 8'h03);
        wr(3'd0, 8'h00);
        // R6: pin with every channel masked, then none masked (codes all 00)
        wr(3'd3, 8'h00); wr(3'd2, 8'h00);
        xtal_clk = 1'b1;
        wr(3'd1, 8'hA6);
        oe_pin_dis = 1'b1; #1;
        chk("R6 all masked", {clk_val, clk_oe}, 8'hFF);
        wr(3'd1, 8'h00);
        chk("R6 none masked", {clk_val, clk_oe}, 8'h0F);
        // R3: channel 3 divider
        oe_pin_dis = 1'b0;
        wr(3'd7, 8'h0C);
        div_clk = 4'b1000; xtal_clk = 1'b0; #1;
        chk("R3 ch3 divider", {clk_val, clk_oe}, 8'h8F);
        // R9: channel 2 power-down
        wr(3'd6, 8'h80);
        chk("R9 ch2 power-down", {4'h0, clk_oe}, 8'h0B);

        finish_run();
    end
endmodule